// File: doc/BRIEF.md
# Isochronous Endpoint Transaction Tracker

This block runs the per-frame transaction flow of a single isochronous device endpoint, in either the transmit or the receive direction. Software arms it with one descriptor at a time: a direction, the frame in which delivery should start, an optional transmit packet-count override, a byte budget, and the queue-head packet count and maximum packet size. After a fixed arming latency the block waits for a start-of-frame whose index has reached the target, then answers IN tokens or accepts OUT data packets for that frame.

It counts packets against a per-frame budget and retires the descriptor when the budget is used up, when a receive packet carries a non-MDATA PID, on a receive error, or at the next frame boundary if the frame was only partly served. On every retirement it raises a request for the next descriptor. Buffer and transaction error flags describe the descriptor that last retired and are cleared when the next one is armed. The payload path, CRC computation and descriptor fetch sit outside.

Top module: `iso_ep_tracker`

## Requirements
- R1: After reset, rsp_valid, rsp_code, retire, buf_err, txn_err and next_prime_req are all 0.
- R2: The per-frame packet budget is dtd_mult_ovr when the descriptor is transmit and dtd_mult_ovr is nonzero; otherwise, including every receive descriptor, it is qh_mult.
- R3: Data PIDs are encoded DATA0=0, DATA1=1, DATA2=2, MDATA=3. An accepted receive packet retires the descriptor when it uses the last packet of the budget, or at once when its PID is not MDATA.
- R4: A receive packet with dat_len greater than the latched maximum packet size is answered with DROP (5), sets buf_err and retires the descriptor.
- R5: A receive packet with dat_len greater than the bytes still left in the descriptor budget (dtd_total minus the bytes of packets stored so far) is answered with DROP, sets buf_err and retires the descriptor.
- R6: A start-of-frame while delivering, after at least one but fewer packets than the budget, sets txn_err and retires; after zero packets the endpoint stays armed and its budget reloads for the new frame.
- R7: An otherwise valid receive packet flagged with dat_crc_err is answered with DROP, sets txn_err and retires the descriptor.
- R8: An arm request completes PRIME_LAT cycles after acceptance; delivery starts at the first start-of-frame seen after completion whose index equals or lies ahead of the target frame, so a start-of-frame during the arming latency slips delivery to the following frame.
- R9: An arm request is accepted only while no descriptor is held. Each retirement gives a one-cycle retire pulse and raises next_prime_req, which stays high until the next accepted arm request; that acceptance also clears buf_err and txn_err.
- R10: Every IN token is answered one cycle later with rsp_valid and a code: SEND (1) when a transmit descriptor is delivering, UNDERRUN (3) plus buf_err when it is delivering but tx_underrun is high, and ZLP (2) in every other state.
- R11: Every data packet is answered one cycle later: STORE (4) when a receive descriptor is delivering and the packet is good, DROP (5) otherwise, with no state change when nothing is delivering.
- R12: SETUP (tok_pid 2) and OUT (tok_pid 0) tokens produce no response and leave all state unchanged; IN is tok_pid 1.
- R13: Frame indices compare modulo 2^FRAME_W: an index counts as reached when (frame_idx − target) mod 2^FRAME_W is below half the range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sof | input | 1 | Start-of-frame event |
| frame_idx | input | FRAME_W | Index of the frame that begins with sof |
| prime_req | input | 1 | Arm request for one descriptor |
| prime_tx | input | 1 | Descriptor direction, 1 = transmit |
| prime_frame | input | FRAME_W | Frame in which delivery should start |
| dtd_mult_ovr | input | MULT_W | Descriptor override of the transmit packet budget, 0 = none |
| dtd_total | input | TOT_W | Descriptor byte budget |
| qh_mult | input | MULT_W | Queue-head packets per frame |
| qh_max_len | input | LEN_W | Queue-head maximum packet size |
| tok_valid | input | 1 | Token event |
| tok_pid | input | 2 | Token kind: 0 OUT, 1 IN, 2 SETUP |
| tx_underrun | input | 1 | Payload for the current IN is short |
| dat_valid | input | 1 | Received data packet event |
| dat_pid | input | 2 | Data PID code |
| dat_len | input | LEN_W | Received byte count |
| dat_crc_err | input | 1 | Received packet failed its CRC |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 3 | Response code |
| retire | output | 1 | Descriptor retired, one cycle |
| buf_err | output | 1 | Buffer error of the current descriptor |
| txn_err | output | 1 | Transaction error of the current descriptor |
| next_prime_req | output | 1 | Request for the next descriptor |

## Verification
The assertions assume at most one of sof, tok_valid and dat_valid per cycle, a nonzero qh_mult, and that the bus-side error rules see a decoded packet length; one of them checks the one-event rule directly. The stimulus keeps to this by driving each event in its own cycle with an idle cycle after it, always arming with qh_mult of 1 to 3, and waiting out the arming latency except in the test that provokes a slipped frame.

// File: rtl/iso_ep_pkg.sv
package iso_ep_pkg;

   typedef enum logic [1:0] {
      EP_IDLE    = 2'd0,
      EP_PRIMING = 2'd1,
      EP_WAIT    = 2'd2,
      EP_ACTIVE  = 2'd3
   } ep_state_e;

   typedef enum logic [2:0] {
      RSP_NONE     = 3'd0,
      RSP_SEND     = 3'd1,
      RSP_ZLP      = 3'd2,
      RSP_UNDERRUN = 3'd3,
      RSP_STORE    = 3'd4,
      RSP_DROP     = 3'd5
   } rsp_e;

   localparam logic [1:0] TOK_OUT   = 2'd0;
   localparam logic [1:0] TOK_IN    = 2'd1;
   localparam logic [1:0] TOK_SETUP = 2'd2;

   localparam logic [1:0] PID_MDATA = 2'd3;

endpackage

// File: rtl/iso_prime_seq.sv
module iso_prime_seq
   import iso_ep_pkg::*;
#(
   parameter int FRAME_W   = 11,
   parameter int PRIME_LAT = 4
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               prime_req,
   input  logic               prime_tx,
   input  logic [FRAME_W-1:0] prime_frame,
   input  logic               sof,
   input  logic [FRAME_W-1:0] frame_idx,
   input  logic               retire_now,
   output ep_state_e          state,
   output logic               dir_tx,
   output logic               prime_acc,
   output logic               frame_go
);

   localparam int LAT_W = (PRIME_LAT < 2) ? 1 : $clog2(PRIME_LAT);
   localparam logic [FRAME_W-1:0] HALF = FRAME_W'(1) << (FRAME_W - 1);

   ep_state_e          state_q;
   logic [FRAME_W-1:0] tgt_q;
   logic               dir_q;
   logic               lat_done;
   logic [FRAME_W-1:0] diff;
   logic               reached;

   assign prime_acc = prime_req && (state_q == EP_IDLE);

   // serial-number compare: target reached when the distance is in the lower half
   assign diff     = frame_idx - tgt_q;
   assign reached  = (diff < HALF);
   assign frame_go = sof && (state_q == EP_WAIT) && reached;

   generate
      if (PRIME_LAT == 0) begin : g_nolat
         assign lat_done = 1'b1;
      end else begin : g_lat
         logic [LAT_W-1:0] lat_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lat_q <= '0;
            end else if (prime_acc) begin
               lat_q <= LAT_W'(PRIME_LAT - 1);
            end else if (state_q == EP_PRIMING && lat_q != '0) begin
               lat_q <= lat_q - 1'b1;
            end
         end
         assign lat_done = (lat_q == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= EP_IDLE;
         tgt_q   <= '0;
         dir_q   <= 1'b0;
      end else begin
         unique case (state_q)
            EP_IDLE: begin
               if (prime_acc) begin
                  state_q <= (PRIME_LAT == 0) ? EP_WAIT : EP_PRIMING;
                  tgt_q   <= prime_frame;
                  dir_q   <= prime_tx;
               end
            end
            EP_PRIMING: begin
               if (lat_done) state_q <= EP_WAIT;
            end
            EP_WAIT: begin
               if (frame_go) state_q <= EP_ACTIVE;
            end
            EP_ACTIVE: begin
               if (retire_now) state_q <= EP_IDLE;
            end
            default: state_q <= EP_IDLE;
         endcase
      end
   end

   assign state  = state_q;
   assign dir_tx = dir_q;

   // R8: delivery only ever begins on a start-of-frame
   p_active_on_sof_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_q == EP_ACTIVE) |-> $past(sof));

endmodule

// File: rtl/iso_pkt_ctr.sv
module iso_pkt_ctr #(
   parameter int MULT_W = 2,
   parameter int LEN_W  = 11,
   parameter int TOT_W  = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prime_acc,
   input  logic              prime_tx,
   input  logic [MULT_W-1:0] dtd_mult_ovr,
   input  logic [TOT_W-1:0]  dtd_total,
   input  logic [MULT_W-1:0] qh_mult,
   input  logic [LEN_W-1:0]  qh_max_len,
   input  logic              load_frame,
   input  logic              pkt_take,
   input  logic              store_take,
   input  logic [LEN_W-1:0]  take_len,
   output logic [MULT_W-1:0] mult_left,
   output logic [MULT_W-1:0] pkt_cnt,
   output logic [MULT_W-1:0] mult_goal,
   output logic [TOT_W-1:0]  bytes_left,
   output logic [LEN_W-1:0]  max_len
);

   logic [MULT_W-1:0] eff_mult;
   logic [MULT_W-1:0] goal_q;
   logic [MULT_W-1:0] left_q;
   logic [MULT_W-1:0] cnt_q;
   logic [TOT_W-1:0]  bytes_q;
   logic [LEN_W-1:0]  max_q;

   assign eff_mult = (prime_tx && dtd_mult_ovr != '0) ? dtd_mult_ovr : qh_mult;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         goal_q  <= '0;
         left_q  <= '0;
         cnt_q   <= '0;
         bytes_q <= '0;
         max_q   <= '0;
      end else if (prime_acc) begin
         goal_q  <= eff_mult;
         bytes_q <= dtd_total;
         max_q   <= qh_max_len;
         left_q  <= '0;
         cnt_q   <= '0;
      end else if (load_frame) begin
         left_q <= goal_q;
         cnt_q  <= '0;
      end else if (pkt_take) begin
         left_q <= left_q - 1'b1;
         cnt_q  <= cnt_q + 1'b1;
         if (store_take) bytes_q <= bytes_q - TOT_W'(take_len);
      end
   end

   assign mult_left  = left_q;
   assign pkt_cnt    = cnt_q;
   assign mult_goal  = goal_q;
   assign bytes_left = bytes_q;
   assign max_len    = max_q;

   // R3: a packet is only ever taken against remaining budget
   p_take_credit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_take |-> (left_q != '0));

endmodule

// File: rtl/iso_resp_unit.sv
module iso_resp_unit
   import iso_ep_pkg::*;
#(
   parameter int MULT_W = 2,
   parameter int LEN_W  = 11,
   parameter int TOT_W  = 16
)(
   input  logic              active,
   input  logic              dir_tx,
   input  logic              sof,
   input  logic              tok_valid,
   input  logic [1:0]        tok_pid,
   input  logic              tx_underrun,
   input  logic              dat_valid,
   input  logic [1:0]        dat_pid,
   input  logic [LEN_W-1:0]  dat_len,
   input  logic              dat_crc_err,
   input  logic [MULT_W-1:0] mult_left,
   input  logic [MULT_W-1:0] pkt_cnt,
   input  logic [MULT_W-1:0] mult_goal,
   input  logic [TOT_W-1:0]  bytes_left,
   input  logic [LEN_W-1:0]  max_len,
   output logic              rsp_valid_d,
   output rsp_e              rsp_code_d,
   output logic              pkt_take,
   output logic              store_take,
   output logic              retire_now,
   output logic              set_buf,
   output logic              set_txn,
   output logic              frame_reload
);

   logic has_credit;
   logic last_pkt;
   logic too_long;
   logic too_many;

   assign has_credit = (mult_left != '0);
   assign last_pkt   = (mult_left == MULT_W'(1));
   assign too_long   = (dat_len > max_len);
   assign too_many   = (TOT_W'(dat_len) > bytes_left);

   always_comb begin
      rsp_valid_d  = 1'b0;
      rsp_code_d   = RSP_NONE;
      pkt_take     = 1'b0;
      store_take   = 1'b0;
      retire_now   = 1'b0;
      set_buf      = 1'b0;
      set_txn      = 1'b0;
      frame_reload = 1'b0;
      if (sof) begin
         if (active) begin
            if (pkt_cnt != '0 && pkt_cnt < mult_goal) begin
               set_txn    = 1'b1;
               retire_now = 1'b1;
            end else begin
               frame_reload = 1'b1;
            end
         end
      end else if (tok_valid && tok_pid == TOK_IN) begin
         rsp_valid_d = 1'b1;
         if (active && dir_tx && has_credit) begin
            pkt_take = 1'b1;
            if (tx_underrun) begin
               rsp_code_d = RSP_UNDERRUN;
               set_buf    = 1'b1;
            end else begin
               rsp_code_d = RSP_SEND;
            end
            if (last_pkt) retire_now = 1'b1;
         end else begin
            rsp_code_d = RSP_ZLP;
         end
      end else if (dat_valid) begin
         rsp_valid_d = 1'b1;
         rsp_code_d  = RSP_DROP;
         if (active && !dir_tx && has_credit) begin
            pkt_take = 1'b1;
            if (too_long || too_many) begin
               set_buf    = 1'b1;
               retire_now = 1'b1;
            end else if (dat_crc_err) begin
               set_txn    = 1'b1;
               retire_now = 1'b1;
            end else begin
               rsp_code_d = RSP_STORE;
               store_take = 1'b1;
               if (last_pkt || dat_pid != PID_MDATA) retire_now = 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/iso_ep_tracker.sv
module iso_ep_tracker
   import iso_ep_pkg::*;
#(
   parameter int FRAME_W   = 11,
   parameter int MULT_W    = 2,
   parameter int LEN_W     = 11,
   parameter int TOT_W     = 16,
   parameter int PRIME_LAT = 4
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sof,
   input  logic [FRAME_W-1:0] frame_idx,
   input  logic               prime_req,
   input  logic               prime_tx,
   input  logic [FRAME_W-1:0] prime_frame,
   input  logic [MULT_W-1:0]  dtd_mult_ovr,
   input  logic [TOT_W-1:0]   dtd_total,
   input  logic [MULT_W-1:0]  qh_mult,
   input  logic [LEN_W-1:0]   qh_max_len,
   input  logic               tok_valid,
   input  logic [1:0]         tok_pid,
   input  logic               tx_underrun,
   input  logic               dat_valid,
   input  logic [1:0]         dat_pid,
   input  logic [LEN_W-1:0]   dat_len,
   input  logic               dat_crc_err,
   output logic               rsp_valid,
   output logic [2:0]         rsp_code,
   output logic               retire,
   output logic               buf_err,
   output logic               txn_err,
   output logic               next_prime_req
);

   generate
      if (FRAME_W < 2) begin : g_bad_frame_w
         $error("FRAME_W must be at least 2");
      end
      if (MULT_W < 1) begin : g_bad_mult_w
         $error("MULT_W must be at least 1");
      end
      if (TOT_W < LEN_W) begin : g_bad_tot_w
         $error("TOT_W must not be narrower than LEN_W");
      end
      if (PRIME_LAT < 0) begin : g_bad_lat
         $error("PRIME_LAT must not be negative");
      end
   endgenerate

   ep_state_e         state;
   logic              dir_tx;
   logic              prime_acc;
   logic              frame_go;
   logic              active;
   logic [MULT_W-1:0] mult_left;
   logic [MULT_W-1:0] pkt_cnt;
   logic [MULT_W-1:0] mult_goal;
   logic [TOT_W-1:0]  bytes_left;
   logic [LEN_W-1:0]  max_len;
   logic              rsp_valid_d;
   rsp_e              rsp_code_d;
   logic              pkt_take;
   logic              store_take;
   logic              retire_now;
   logic              set_buf;
   logic              set_txn;
   logic              frame_reload;

   logic              rsp_valid_q;
   rsp_e              rsp_code_q;
   logic              retire_q;
   logic              buf_q;
   logic              txn_q;
   logic              next_q;

   assign active = (state == EP_ACTIVE);

   iso_prime_seq #(
      .FRAME_W   (FRAME_W),
      .PRIME_LAT (PRIME_LAT)
   ) seq_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .prime_req   (prime_req),
      .prime_tx    (prime_tx),
      .prime_frame (prime_frame),
      .sof         (sof),
      .frame_idx   (frame_idx),
      .retire_now  (retire_now),
      .state       (state),
      .dir_tx      (dir_tx),
      .prime_acc   (prime_acc),
      .frame_go    (frame_go)
   );

   iso_pkt_ctr #(
      .MULT_W (MULT_W),
      .LEN_W  (LEN_W),
      .TOT_W  (TOT_W)
   ) ctr_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .prime_acc    (prime_acc),
      .prime_tx     (prime_tx),
      .dtd_mult_ovr (dtd_mult_ovr),
      .dtd_total    (dtd_total),
      .qh_mult      (qh_mult),
      .qh_max_len   (qh_max_len),
      .load_frame   (frame_go | frame_reload),
      .pkt_take     (pkt_take),
      .store_take   (store_take),
      .take_len     (dat_len),
      .mult_left    (mult_left),
      .pkt_cnt      (pkt_cnt),
      .mult_goal    (mult_goal),
      .bytes_left   (bytes_left),
      .max_len      (max_len)
   );

   iso_resp_unit #(
      .MULT_W (MULT_W),
      .LEN_W  (LEN_W),
      .TOT_W  (TOT_W)
   ) rsp_i (
      .active       (active),
      .dir_tx       (dir_tx),
      .sof          (sof),
      .tok_valid    (tok_valid),
      .tok_pid      (tok_pid),
      .tx_underrun  (tx_underrun),
      .dat_valid    (dat_valid),
      .dat_pid      (dat_pid),
      .dat_len      (dat_len),
      .dat_crc_err  (dat_crc_err),
      .mult_left    (mult_left),
      .pkt_cnt      (pkt_cnt),
      .mult_goal    (mult_goal),
      .bytes_left   (bytes_left),
      .max_len      (max_len),
      .rsp_valid_d  (rsp_valid_d),
      .rsp_code_d   (rsp_code_d),
      .pkt_take     (pkt_take),
      .store_take   (store_take),
      .retire_now   (retire_now),
      .set_buf      (set_buf),
      .set_txn      (set_txn),
      .frame_reload (frame_reload)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         rsp_code_q  <= RSP_NONE;
         retire_q    <= 1'b0;
         buf_q       <= 1'b0;
         txn_q       <= 1'b0;
         next_q      <= 1'b0;
      end else begin
         rsp_valid_q <= rsp_valid_d;
         rsp_code_q  <= rsp_code_d;
         retire_q    <= retire_now;
         if (prime_acc) begin
            buf_q  <= 1'b0;
            txn_q  <= 1'b0;
            next_q <= 1'b0;
         end else begin
            if (set_buf)    buf_q  <= 1'b1;
            if (set_txn)    txn_q  <= 1'b1;
            if (retire_now) next_q <= 1'b1;
         end
      end
   end

   assign rsp_valid      = rsp_valid_q;
   assign rsp_code       = rsp_code_q;
   assign retire         = retire_q;
   assign buf_err        = buf_q;
   assign txn_err        = txn_q;
   assign next_prime_req = next_q;

   // input rule: one bus event per cycle (R12 relies on it)
   p_one_event_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sof, tok_valid, dat_valid}));

   // R10: IN while not delivering a transmit descriptor gets a zero-length reply
   p_zlp_unprimed_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && tok_pid == TOK_IN && !active) |=> (rsp_valid && rsp_code == 3'(RSP_ZLP)));

   // R12: SETUP produces no response
   p_setup_silent_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && tok_pid == TOK_SETUP) |=> !rsp_valid);

   // R9: a retirement always leaves the next-descriptor request raised
   p_retire_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
      retire |-> next_prime_req);

   // R4: an oversized receive packet flags a buffer error and retires
   p_overflow_buf_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_valid && active && !dir_tx && mult_left != '0 && dat_len > max_len)
      |=> (buf_err && retire && rsp_code == 3'(RSP_DROP)));

   // R7: a CRC failure on an otherwise fitting packet flags a transaction error
   p_crc_txn_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_valid && active && !dir_tx && mult_left != '0 && dat_len <= max_len &&
       TOT_W'(dat_len) <= bytes_left && dat_crc_err)
      |=> (txn_err && retire));

endmodule

// File: tb/iso_ep_tracker_tb.sv
`timescale 1ns/1ps
module iso_ep_tracker_tb_top;

   localparam int FRAME_W   = 11;
   localparam int MULT_W    = 2;
   localparam int LEN_W     = 11;
   localparam int TOT_W     = 16;
   localparam int PRIME_LAT = 4;

   // [16] data event, [15:14] pid, [13:6] len, [5] crc, [4] underrun,
   // [3] response expected, [2:0] expected code
   localparam int NVEC = 6;
   localparam logic [16:0] VEC [NVEC] = '{
      {1'b0, 2'd1, 8'd0,   1'b0, 1'b0, 1'b1, 3'd2},
      {1'b0, 2'd1, 8'd0,   1'b0, 1'b1, 1'b1, 3'd2},
      {1'b0, 2'd2, 8'd0,   1'b0, 1'b0, 1'b0, 3'd0},
      {1'b0, 2'd0, 8'd0,   1'b0, 1'b0, 1'b0, 3'd0},
      {1'b1, 2'd3, 8'd20,  1'b0, 1'b0, 1'b1, 3'd5},
      {1'b1, 2'd0, 8'd200, 1'b1, 1'b0, 1'b1, 3'd5}
   };

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               sof = 1'b0;
   logic [FRAME_W-1:0] frame_idx = '0;
   logic               prime_req = 1'b0;
   logic               prime_tx = 1'b0;
   logic [FRAME_W-1:0] prime_frame = '0;
   logic [MULT_W-1:0]  dtd_mult_ovr = '0;
   logic [TOT_W-1:0]   dtd_total = '0;
   logic [MULT_W-1:0]  qh_mult = '0;
   logic [LEN_W-1:0]   qh_max_len = '0;
   logic               tok_valid = 1'b0;
   logic [1:0]         tok_pid = '0;
   logic               tx_underrun = 1'b0;
   logic               dat_valid = 1'b0;
   logic [1:0]         dat_pid = '0;
   logic [LEN_W-1:0]   dat_len = '0;
   logic               dat_crc_err = 1'b0;
   logic               rsp_valid;
   logic [2:0]         rsp_code;
   logic               retire;
   logic               buf_err;
   logic               txn_err;
   logic               next_prime_req;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  finished = 1'b0;

   always #2 clk = ~clk;

   iso_ep_tracker #(
      .FRAME_W(FRAME_W), .MULT_W(MULT_W), .LEN_W(LEN_W), .TOT_W(TOT_W), .PRIME_LAT(PRIME_LAT)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .sof(sof), .frame_idx(frame_idx),
      .prime_req(prime_req), .prime_tx(prime_tx), .prime_frame(prime_frame),
      .dtd_mult_ovr(dtd_mult_ovr), .dtd_total(dtd_total), .qh_mult(qh_mult),
      .qh_max_len(qh_max_len), .tok_valid(tok_valid), .tok_pid(tok_pid),
      .tx_underrun(tx_underrun), .dat_valid(dat_valid), .dat_pid(dat_pid),
      .dat_len(dat_len), .dat_crc_err(dat_crc_err), .rsp_valid(rsp_valid),
      .rsp_code(rsp_code), .retire(retire), .buf_err(buf_err), .txn_err(txn_err),
      .next_prime_req(next_prime_req)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_rsp(input string tag, input int v, input int code);
      chk({tag, " rsp_valid"}, int'(rsp_valid), v);
      chk({tag, " rsp_code"}, int'(rsp_code), code);
   endtask

   task automatic ev_tok(input logic [1:0] pid, input logic und);
      @(negedge clk);
      tok_valid = 1'b1; tok_pid = pid; tx_underrun = und;
      @(negedge clk);
      tok_valid = 1'b0; tx_underrun = 1'b0;
   endtask

   task automatic ev_dat(input logic [1:0] pid, input int len, input logic crc);
      @(negedge clk);
      dat_valid = 1'b1; dat_pid = pid; dat_len = LEN_W'(len); dat_crc_err = crc;
      @(negedge clk);
      dat_valid = 1'b0; dat_crc_err = 1'b0;
   endtask

   task automatic ev_sof(input int f);
      @(negedge clk);
      sof = 1'b1; frame_idx = FRAME_W'(f);
      @(negedge clk);
      sof = 1'b0;
   endtask

   task automatic ev_prime(input logic tx, input int f, input int ovr, input int total,
                           input int mult, input int maxl, input bit settle);
      @(negedge clk);
      prime_req = 1'b1; prime_tx = tx; prime_frame = FRAME_W'(f);
      dtd_mult_ovr = MULT_W'(ovr); dtd_total = TOT_W'(total);
      qh_mult = MULT_W'(mult); qh_max_len = LEN_W'(maxl);
      @(negedge clk);
      prime_req = 1'b0;
      if (settle) repeat (PRIME_LAT + 2) @(negedge clk);
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 rsp_valid", int'(rsp_valid), 0);
      chk("R1 rsp_code", int'(rsp_code), 0);
      chk("R1 retire", int'(retire), 0);
      chk("R1 buf_err", int'(buf_err), 0);
      chk("R1 txn_err", int'(txn_err), 0);
      chk("R1 next_prime_req", int'(next_prime_req), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 R11 R12: table of events on an idle endpoint
      for (int i = 0; i < NVEC; i++) begin
         if (VEC[i][16])
            ev_dat(VEC[i][15:14], int'(VEC[i][13:6]), VEC[i][5]);
         else
            ev_tok(VEC[i][15:14], VEC[i][4]);
         chk_rsp("R10_R11_R12 idle table", int'(VEC[i][3]), int'(VEC[i][2:0]));
         chk("R11 idle no retire", int'(retire), 0);
         chk("R11 idle buf_err", int'(buf_err), 0);
         chk("R11 idle txn_err", int'(txn_err), 0);
      end

      // R2 R8: transmit with override 1, target 5; frame 4 is too early
      ev_prime(1'b1, 5, 1, 1000, 3, 512, 1'b1);
      ev_sof(4);
      ev_tok(2'd1, 1'b0);
      chk_rsp("R8 before target", 1, 2);
      ev_sof(5);
      ev_tok(2'd1, 1'b0);
      chk_rsp("R2 override send", 1, 1);
      chk("R2 override retires after one", int'(retire), 1);
      chk("R9 next request raised", int'(next_prime_req), 1);
      @(negedge clk);
      chk("R9 retire is a pulse", int'(retire), 0);
      ev_tok(2'd1, 1'b0);
      chk_rsp("R10 after retire", 1, 2);

      // R2 R10: zero override uses queue-head count 3, last IN underruns
      ev_prime(1'b1, 6, 0, 1000, 3, 512, 1'b1);
      chk("R9 next request cleared", int'(next_prime_req), 0);
      ev_sof(6);
      ev_tok(2'd1, 1'b0);
      chk_rsp("R2 send 1", 1, 1);
      chk("R2 no retire 1", int'(retire), 0);
      ev_tok(2'd1, 1'b0);
      chk("R2 no retire 2", int'(retire), 0);
      ev_tok(2'd1, 1'b1);
      chk_rsp("R10 underrun", 1, 3);
      chk("R10 underrun buf_err", int'(buf_err), 1);
      chk("R2 retire on third", int'(retire), 1);

      // R2 R5 R9: receive ignores override; byte budget 100
      ev_prime(1'b0, 7, 1, 100, 3, 64, 1'b1);
      chk("R9 buf_err cleared", int'(buf_err), 0);
      ev_sof(7);
      ev_dat(2'd3, 40, 1'b0);
      chk_rsp("R11 store", 1, 4);
      chk("R2 rx ignores override", int'(retire), 0);
      ev_dat(2'd3, 40, 1'b0);
      chk_rsp("R11 store 2", 1, 4);
      chk("R5 no retire yet", int'(retire), 0);
      ev_dat(2'd3, 30, 1'b0);
      chk_rsp("R5 budget overflow drop", 1, 5);
      chk("R5 buf_err", int'(buf_err), 1);
      chk("R5 retire", int'(retire), 1);

      // R3: non-MDATA PID retires early
      ev_prime(1'b0, 8, 0, 1000, 3, 64, 1'b1);
      ev_sof(8);
      ev_dat(2'd1, 10, 1'b0);
      chk_rsp("R3 data1 store", 1, 4);
      chk("R3 early retire", int'(retire), 1);

      // R3: budget of 2 MDATA packets
      ev_prime(1'b0, 9, 0, 1000, 2, 64, 1'b1);
      ev_sof(9);
      ev_dat(2'd3, 10, 1'b0);
      chk("R3 first mdata no retire", int'(retire), 0);
      ev_dat(2'd3, 10, 1'b0);
      chk("R3 count retire", int'(retire), 1);
      chk("R3 clean buf_err", int'(buf_err), 0);
      chk("R3 clean txn_err", int'(txn_err), 0);

      // R4: longer than max packet size
      ev_prime(1'b0, 10, 0, 1000, 2, 64, 1'b1);
      ev_sof(10);
      ev_dat(2'd3, 65, 1'b0);
      chk_rsp("R4 drop", 1, 5);
      chk("R4 buf_err", int'(buf_err), 1);
      chk("R4 retire", int'(retire), 1);
      chk("R4 txn_err", int'(txn_err), 0);

      // R7: CRC error
      ev_prime(1'b0, 11, 0, 1000, 2, 64, 1'b1);
      ev_sof(11);
      ev_dat(2'd3, 10, 1'b1);
      chk_rsp("R7 drop", 1, 5);
      chk("R7 txn_err", int'(txn_err), 1);
      chk("R7 buf_err", int'(buf_err), 0);
      chk("R7 retire", int'(retire), 1);

      // R6: partial frame
      ev_prime(1'b1, 12, 0, 1000, 3, 512, 1'b1);
      ev_sof(12);
      ev_tok(2'd1, 1'b0);
      ev_sof(13);
      chk("R6 partial retire", int'(retire), 1);
      chk("R6 partial txn_err", int'(txn_err), 1);

      // R6: empty frame keeps the endpoint armed
      ev_prime(1'b1, 14, 0, 1000, 2, 512, 1'b1);
      ev_sof(14);
      ev_sof(15);
      chk("R6 empty frame no retire", int'(retire), 0);
      chk("R6 empty frame no txn_err", int'(txn_err), 0);
      ev_tok(2'd1, 1'b0);
      chk_rsp("R6 still armed", 1, 1);
      ev_tok(2'd1, 1'b0);
      chk("R6 reloaded budget retires", int'(retire), 1);

      // R8: SOF during arming latency slips to the next frame
      ev_prime(1'b1, 20, 0, 1000, 1, 512, 1'b0);
      ev_sof(20);
      ev_tok(2'd1, 1'b0);
      chk_rsp("R8 not yet armed", 1, 2);
      ev_sof(21);
      ev_tok(2'd1, 1'b0);
      chk_rsp("R8 slipped delivery", 1, 1);
      chk("R8 slipped retire", int'(retire), 1);

      // R13: wraparound of the frame index
      ev_prime(1'b1, 0, 0, 1000, 1, 512, 1'b1);
      ev_sof(2047);
      ev_tok(2'd1, 1'b0);
      chk_rsp("R13 2047 before 0", 1, 2);
      ev_sof(0);
      ev_tok(2'd1, 1'b0);
      chk_rsp("R13 deliver at 0", 1, 1);
      ev_prime(1'b1, 2047, 0, 1000, 1, 512, 1'b1);
      ev_sof(0);
      ev_tok(2'd1, 1'b0);
      chk_rsp("R13 0 is past 2047", 1, 1);

      // R9: arm request ignored while a descriptor is held
      ev_prime(1'b1, 30, 0, 1000, 1, 512, 1'b1);
      ev_prime(1'b0, 31, 0, 1000, 3, 64, 1'b1);
      ev_sof(30);
      ev_tok(2'd1, 1'b0);
      chk_rsp("R9 first descriptor kept", 1, 1);
      chk("R9 kept retire", int'(retire), 1);

      // R12: SETUP and OUT while delivering change nothing
      ev_prime(1'b1, 40, 0, 1000, 1, 512, 1'b1);
      ev_sof(40);
      ev_tok(2'd2, 1'b0);
      chk("R12 setup silent", int'(rsp_valid), 0);
      ev_tok(2'd0, 1'b0);
      chk("R12 out silent", int'(rsp_valid), 0);
      ev_tok(2'd1, 1'b0);
      chk_rsp("R12 state kept", 1, 1);
      chk("R12 retire after", int'(retire), 1);

      repeat (2) @(negedge clk);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule